// File: doc/BRIEF.md
# Frame Transfer Handshake Controller

This block connects a host that moves single 8-bit pixel words through simple register-style ports to a frame filter and its two memories. It runs one frame at a time through three phases that never overlap. In the load phase the host keeps `valid_i` high and strobes pixels in raster order. Each accepted pixel becomes a write into an external frame memory. When the frame is full, a rising edge on `start_i` sends a launch pulse to the filter. The controller then stays in the run phase until the filter reports completion. In the readback phase each read strobe fetches the next processed pixel from an external result memory, and that pixel is held on a registered output.

The frame memory and the result memory sit outside the block. The controller only drives their addresses and enables. The result memory is taken to have a combinational read. The frame size is set by the image width and height parameters, which default to 128 by 128. At those defaults a frame is 16384 transfers in each direction.

Top module: `frame_xfer_ctrl`

## Requirements
- R1: After reset, `busy_o`, `ready_o`, `err_o`, `mem_we_o`, `flt_start_o`, `res_re_o` and `rdata_o` are all zero, and the block is in the load phase with no pixels counted.
- R2: A pixel is accepted only in the load phase, only while both `valid_i` and `wr_i` are high, and only while fewer than IMG_W*IMG_H pixels have been taken. When a pixel is accepted, `mem_we_o` is high in that same cycle, `mem_wdata_o` equals `wdata_i`, and `mem_waddr_o` equals the number of pixels accepted before it (raster index row*IMG_W+col).
- R3: Once IMG_W*IMG_H pixels have been accepted, further write strobes leave `mem_we_o` low.
- R4: A rising edge on `start_i` in the load phase with a full frame produces a one-cycle `flt_start_o` pulse in the next cycle. `busy_o` also rises in that next cycle.
- R5: A rising edge on `start_i` in the load phase with a frame that is not full is ignored: `busy_o` and `flt_start_o` stay low. The same edge sets `err_o`, which stays high until reset.
- R6: `flt_done_i` high while `busy_o` is high makes `busy_o` fall and `ready_o` rise in the next cycle. `busy_o` and `ready_o` are never high together.
- R7: In the readback phase, each `rd_i` raises `res_re_o` in the same cycle, with `res_raddr_o` equal to the number of reads already done. `rdata_o` shows the result word from that address in the next cycle and holds its value in every cycle without a read.
- R8: The read that takes the last pixel drops `ready_o` in the next cycle and returns the block to the load phase with its counts cleared, so the next accepted pixel goes to address 0.
- R9: `rd_i` outside the readback phase leaves `res_re_o` low and `rdata_o` unchanged. `wr_i` outside the load phase leaves `mem_we_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Host level that enables pixel loading |
| wr_i | input | 1 | Pixel write strobe |
| wdata_i | input | DATA_W | Pixel written by the host |
| start_i | input | 1 | Launch request, acted on at its rising edge |
| rd_i | input | 1 | Result read strobe |
| rdata_o | output | DATA_W | Registered result word |
| busy_o | output | 1 | Filter running |
| ready_o | output | 1 | Results available for readback |
| err_o | output | 1 | Sticky flag for a start on an incomplete frame |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_waddr_o | output | AW | Frame memory write address |
| mem_wdata_o | output | DATA_W | Frame memory write data |
| flt_start_o | output | 1 | One-cycle filter launch pulse |
| flt_done_i | input | 1 | Filter completion |
| res_re_o | output | 1 | Result memory read enable |
| res_raddr_o | output | AW | Result memory read address |
| res_rdata_i | input | DATA_W | Result memory read data, combinational |

## Verification
The bench mixes two kinds of stimulus. Random gaps and invalid write attempts are spread through a full frame load and a full readback. Directed cases cover the phase edges. It targets a start edge on an empty frame: a controller that got this wrong would launch the filter on garbage, or would fail to latch the error flag. It presses extra write strobes after the frame fills: a counter that wraps would overwrite pixel 0. It also strobes reads during the run phase and checks that the output holds: a missing phase gate would show a changed output word or a skipped address. After the last read, a single new write must land at address 0, which exposes a counter that is not cleared between frames.

// File: rtl/frame_xfer_pkg.sv
package frame_xfer_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_RUN  = 2'd1,
    PH_READ = 2'd2
  } phase_e;
endpackage

// File: rtl/xfer_addr_cnt.sv
module xfer_addr_cnt #(
  parameter int WIDTH = 15,
  parameter int LIMIT = 16384
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             at_lim_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_lim_o = (cnt_q == WIDTH'(LIMIT));
endmodule

// File: rtl/start_edge_det.sv
module start_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/xfer_phase_fsm.sv
module xfer_phase_fsm
  import frame_xfer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  logic   wr_i,
  input  logic   rd_i,
  input  logic   start_rise_i,
  input  logic   full_i,
  input  logic   rd_last_i,
  input  logic   done_i,
  output phase_e phase_o,
  output logic   wr_acc_o,
  output logic   rd_acc_o,
  output logic   wrap_o,
  output logic   flt_start_o,
  output logic   err_o
);
  phase_e phase_q, phase_d;
  logic   start_ok, start_bad;
  logic   flt_start_q, err_q;

  assign wr_acc_o  = (phase_q == PH_LOAD) & valid_i & wr_i & ~full_i;
  assign rd_acc_o  = (phase_q == PH_READ) & rd_i;
  assign start_ok  = (phase_q == PH_LOAD) & start_rise_i & full_i;
  assign start_bad = (phase_q == PH_LOAD) & start_rise_i & ~full_i;
  assign wrap_o    = rd_acc_o & rd_last_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_LOAD: if (start_ok) phase_d = PH_RUN;
      PH_RUN:  if (done_i)   phase_d = PH_READ;
      PH_READ: if (wrap_o)   phase_d = PH_LOAD;
      default:               phase_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_LOAD;
      flt_start_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      flt_start_q <= start_ok;
      if (start_bad) err_q <= 1'b1;
    end
  end

  assign phase_o     = phase_q;
  assign flt_start_o = flt_start_q;
  assign err_o       = err_q;
endmodule

// File: rtl/frame_xfer_ctrl.sv
module frame_xfer_ctrl
  import frame_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 128,
  parameter int IMG_H  = 128,
  localparam int NPIX  = IMG_W * IMG_H,
  localparam int AW    = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              err_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              flt_start_o,
  input  logic              flt_done_i,
  output logic              res_re_o,
  output logic [AW-1:0]     res_raddr_o,
  input  logic [DATA_W-1:0] res_rdata_i
);
  phase_e            phase;
  logic              start_rise, full, rd_last;
  logic              wr_acc, rd_acc, wrap;
  logic [AW:0]       wr_cnt;
  logic [AW-1:0]     rd_cnt;
  logic [DATA_W-1:0] rdata_q;

  start_edge_det u_start_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (start_i),
    .rise_o (start_rise)
  );

  // write side counts to NPIX so a full frame is distinguishable from empty
  xfer_addr_cnt #(.WIDTH(AW + 1), .LIMIT(NPIX)) u_wr_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wrap),
    .inc_i    (wr_acc),
    .cnt_o    (wr_cnt),
    .at_lim_o (full)
  );

  xfer_addr_cnt #(.WIDTH(AW), .LIMIT(NPIX - 1)) u_rd_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wrap),
    .inc_i    (rd_acc),
    .cnt_o    (rd_cnt),
    .at_lim_o (rd_last)
  );

  xfer_phase_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .wr_i         (wr_i),
    .rd_i         (rd_i),
    .start_rise_i (start_rise),
    .full_i       (full),
    .rd_last_i    (rd_last),
    .done_i       (flt_done_i),
    .phase_o      (phase),
    .wr_acc_o     (wr_acc),
    .rd_acc_o     (rd_acc),
    .wrap_o       (wrap),
    .flt_start_o  (flt_start_o),
    .err_o        (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_acc) rdata_q <= res_rdata_i;
  end

  assign rdata_o     = rdata_q;
  assign busy_o      = (phase == PH_RUN);
  assign ready_o     = (phase == PH_READ);
  assign mem_we_o    = wr_acc;
  assign mem_waddr_o = wr_cnt[AW-1:0];
  assign mem_wdata_o = wdata_i;
  assign res_re_o    = rd_acc;
  assign res_raddr_o = rd_cnt;
endmodule

// File: rtl/frame_xfer_ctrl_chk.sv
module frame_xfer_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              busy_o,
  input logic              ready_o,
  input logic              err_o,
  input logic              mem_we_o,
  input logic              flt_start_o,
  input logic              flt_done_i,
  input logic              res_re_o
);
  AST_WE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (valid_i && wr_i)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!busy_o && !ready_o)); // R9
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_start_o |=> !flt_start_o); // R4
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_start_o |-> busy_o); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R5
  AST_DONE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && flt_done_i) |=> (!busy_o && ready_o)); // R6
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && ready_o)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_re_o |=> $stable(rdata_o)); // R7
  AST_RE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_re_o |-> (ready_o && rd_i)); // R9
endmodule

bind frame_xfer_ctrl frame_xfer_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .busy_o      (busy_o),
  .ready_o     (ready_o),
  .err_o       (err_o),
  .mem_we_o    (mem_we_o),
  .flt_start_o (flt_start_o),
  .flt_done_i  (flt_done_i),
  .res_re_o    (res_re_o)
);

// File: tb/frame_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module frame_xfer_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int IMG_W  = 128;
  localparam int IMG_H  = 128;
  localparam int NPIX   = IMG_W * IMG_H;
  localparam int AW     = $clog2(NPIX);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0, wr_i = 1'b0, start_i = 1'b0, rd_i = 1'b0;
  logic              flt_done_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o, mem_wdata_o, res_rdata_i;
  logic              busy_o, ready_o, err_o, mem_we_o, flt_start_o, res_re_o;
  logic [AW-1:0]     mem_waddr_o, res_raddr_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [DATA_W-1:0] res_f(input int a);
    int v;
    v = (a * 37) ^ (a >> 7) ^ 8'hA5;
    return v[DATA_W-1:0];
  endfunction

  assign res_rdata_i = res_f(int'(res_raddr_o));

  frame_xfer_ctrl #(.DATA_W(DATA_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .start_i(start_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .busy_o(busy_o), .ready_o(ready_o), .err_o(err_o), .mem_we_o(mem_we_o),
    .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .flt_start_o(flt_start_o), .flt_done_i(flt_done_i), .res_re_o(res_re_o),
    .res_raddr_o(res_raddr_o), .res_rdata_i(res_rdata_i)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 200000) begin
      chk(1'b0, "watchdog", cycles, 200000);
      report();
    end
  end

  initial begin
    logic [DATA_W-1:0] last_rd;
    void'($urandom(32'd20240611));
    cyc(); cyc();
    // R1 reset state
    chk({busy_o, ready_o, err_o, mem_we_o, flt_start_o, res_re_o} == 6'b0, "R1 flags", 0, 0);
    chk(rdata_o == '0, "R1 rdata", int'(rdata_o), 0);
    rst_ni = 1'b1;
    cyc();

    // R9 reads in load phase ignored
    rd_i = 1'b1; #0.5;
    chk(res_re_o == 1'b0, "R9 re in load", int'(res_re_o), 0);
    cyc(); rd_i = 1'b0;
    chk(rdata_o == '0, "R9 rdata in load", int'(rdata_o), 0);

    // R2 writes with valid low ignored
    wr_i = 1'b1; wdata_i = 8'h3C; #0.5;
    chk(mem_we_o == 1'b0, "R2 no valid", int'(mem_we_o), 0);
    cyc(); wr_i = 1'b0;

    // R5 start on empty frame
    start_i = 1'b1; cyc(); start_i = 1'b0;
    chk(busy_o == 1'b0 && flt_start_o == 1'b0, "R5 ignored start", int'(busy_o), 0);
    chk(err_o == 1'b1, "R5 err set", int'(err_o), 1);

    // R2 load a full frame with random gaps and invalid attempts
    for (int i = 0; i < NPIX; i++) begin
      int gap;
      logic [DATA_W-1:0] d;
      gap = int'($urandom_range(0, 2));
      for (int g = 0; g < gap; g++) begin
        valid_i = 1'b0; wr_i = $urandom_range(0, 1) == 1; #0.5;
        chk(mem_we_o == 1'b0, "R2 gap", int'(mem_we_o), 0);
        cyc();
      end
      d = DATA_W'($urandom);
      valid_i = 1'b1; wr_i = 1'b1; wdata_i = d; #0.5;
      chk(mem_we_o == 1'b1, "R2 we", int'(mem_we_o), 1);
      chk(int'(mem_waddr_o) == i, "R2 addr", int'(mem_waddr_o), i);
      chk(mem_wdata_o == d, "R2 data", int'(mem_wdata_o), int'(d));
      cyc();
    end
    // R3 writes past full frame
    for (int k = 0; k < 4; k++) begin
      #0.5;
      chk(mem_we_o == 1'b0, "R3 overflow", int'(mem_we_o), 0);
      cyc();
    end
    wr_i = 1'b0; valid_i = 1'b0;
    chk(err_o == 1'b1, "R5 err sticky", int'(err_o), 1);

    // R4 launch
    start_i = 1'b1; cyc(); start_i = 1'b0;
    chk(flt_start_o == 1'b1, "R4 pulse", int'(flt_start_o), 1);
    chk(busy_o == 1'b1, "R4 busy", int'(busy_o), 1);
    cyc();
    chk(flt_start_o == 1'b0, "R4 pulse width", int'(flt_start_o), 0);
    chk(busy_o == 1'b1 && ready_o == 1'b0, "R4 busy held", int'(busy_o), 1);

    // R9 strobes during run phase
    for (int k = 0; k < 6; k++) begin
      rd_i = 1'b1; valid_i = 1'b1; wr_i = 1'b1; #0.5;
      chk(res_re_o == 1'b0, "R9 re in run", int'(res_re_o), 0);
      chk(mem_we_o == 1'b0, "R9 we in run", int'(mem_we_o), 0);
      cyc();
      chk(rdata_o == '0, "R9 rdata in run", int'(rdata_o), 0);
    end
    rd_i = 1'b0; valid_i = 1'b0; wr_i = 1'b0;

    // R6 done
    flt_done_i = 1'b1; cyc(); flt_done_i = 1'b0;
    chk(busy_o == 1'b0, "R6 busy fall", int'(busy_o), 0);
    chk(ready_o == 1'b1, "R6 ready rise", int'(ready_o), 1);

    // R7 readback
    last_rd = '0;
    for (int i = 0; i < NPIX; i++) begin
      int gap;
      gap = int'($urandom_range(0, 2));
      for (int g = 0; g < gap; g++) begin
        rd_i = 1'b0; cyc();
        chk(rdata_o == last_rd, "R7 hold", int'(rdata_o), int'(last_rd));
      end
      rd_i = 1'b1; #0.5;
      chk(res_re_o == 1'b1, "R7 re", int'(res_re_o), 1);
      chk(int'(res_raddr_o) == i, "R7 addr", int'(res_raddr_o), i);
      cyc(); rd_i = 1'b0;
      last_rd = res_f(i);
      chk(rdata_o == last_rd, "R7 data", int'(rdata_o), int'(last_rd));
    end
    // R8 back to load
    chk(ready_o == 1'b0 && busy_o == 1'b0, "R8 idle", int'(ready_o), 0);
    rd_i = 1'b1; cyc(); rd_i = 1'b0;
    chk(rdata_o == last_rd, "R9 rdata after wrap", int'(rdata_o), int'(last_rd));
    valid_i = 1'b1; wr_i = 1'b1; wdata_i = 8'h77; #0.5;
    chk(mem_we_o == 1'b1 && mem_waddr_o == '0, "R8 next frame addr", int'(mem_waddr_o), 0);
    cyc(); valid_i = 1'b0; wr_i = 1'b0;

    // R5 err clears only by reset
    rst_ni = 1'b0; cyc(); rst_ni = 1'b1; cyc();
    chk(err_o == 1'b0, "R5 err cleared by reset", int'(err_o), 0);
    chk(rdata_o == '0, "R1 rdata after reset", int'(rdata_o), 0);
    report();
  end
endmodule